// File: doc/BRIEF.md
# Four-Phase Request/Acknowledge Bus Controller Pair

This block holds both ends of a return-to-zero strobe bus: a master-side controller that turns a one-cycle command into a bus transaction, and a slave-side controller that turns that transaction into a local device access. The bus carries an address, a direction line, a shared data path, and a request/acknowledge strobe pair. Each strobe is passed through a two-flop synchronizer before the receiving side uses it. This lets both controllers run as ordinary synchronous state machines, while the strobes behave as if they crossed a clock boundary.

A host pulses `cmd_valid` with direction, address and write data. The master takes the bus, holds the address and direction for a parameterised decode interval, and then raises request. The slave presents the access to its device and waits as long as the device takes. It raises acknowledge when write data has been taken or when read data is on the bus. The master then drops request, capturing read data at that moment. The slave drops acknowledge only after it has seen request fall. The master reports completion once acknowledge is low. If acknowledge does not arrive within a time limit, the master abandons the transfer and reports a timeout instead.

Top module: `hs_bus_top`

## Requirements
- R1: While reset is held and right after it, `bus_req`, `bus_ack`, `bus_own`, `slv_drive`, `dev_sel`, `cmd_busy`, `cmd_done` and `cmd_timeout` are all 0.
- R2: Request is raised only while the master owns the bus, and `bus_addr` at that point equals the accepted command address.
- R3: `bus_req` rises exactly DECODE_CYC cycles after `bus_own` rises (DECODE_CYC is at least 1).
- R4: For a write (`cmd_write`=1), the device sees `dev_sel` with `dev_write`=1, and `dev_addr`/`dev_wdata` equal to the command values. The slave acknowledges only after `dev_ready`.
- R5: For a read (`cmd_write`=0), `cmd_rdata` after completion equals the `dev_rdata` value given at the device's `dev_ready` cycle.
- R6: The master drops request only after acknowledge has been high for at least three cycles (synchronizer plus decision), unless it is timing out.
- R7: The slave drops acknowledge only after request has been low for at least three cycles.
- R8: `cmd_done` pulses exactly once per completed transfer, in a cycle where both strobes are low.
- R9: `slv_drive` is high only during a read while acknowledge is high; otherwise the slave does not drive data.
- R10: If the synchronized acknowledge is not seen within TIMEOUT_CYC cycles of request rising, request is held for exactly TIMEOUT_CYC cycles, `cmd_timeout` pulses once, and `cmd_done` does not pulse.
- R11: Acknowledge seen in the final cycle of the timeout window completes the transfer normally. With DECODE_CYC-independent strobe latency, a device that asserts `dev_ready` L cycles into `dev_sel` completes iff L <= TIMEOUT_CYC-7.
- R12: Command inputs presented while `cmd_busy` is high are ignored: the address, direction and data of the transfer in progress do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | One-cycle command strobe from the host |
| cmd_write | input | 1 | 1 = write, 0 = read |
| cmd_addr | input | AW | Command address |
| cmd_wdata | input | DW | Command write data |
| cmd_busy | output | 1 | Master is handling a transfer |
| cmd_done | output | 1 | One-cycle completion pulse |
| cmd_timeout | output | 1 | One-cycle timeout pulse |
| cmd_rdata | output | DW | Read data captured at request drop |
| bus_own | output | 1 | Master drives address/direction |
| bus_req | output | 1 | Request strobe |
| bus_ack | output | 1 | Acknowledge strobe |
| bus_write | output | 1 | Bus direction line |
| bus_addr | output | AW | Bus address |
| bus_data | output | DW | Resolved bus data |
| slv_drive | output | 1 | Slave drive enable on the data bus |
| dev_sel | output | 1 | Device access in progress |
| dev_write | output | 1 | Device access direction |
| dev_addr | output | AW | Device address |
| dev_wdata | output | DW | Device write data |
| dev_ready | input | 1 | Device finished the access |
| dev_rdata | input | DW | Device read data |

## Verification
The two functions that can meet in one cycle are timeout expiry and arrival of the synchronized acknowledge. The bench sweeps device latency across the range where acknowledge lands before, exactly on, and one cycle after the last cycle of the timeout window, for both directions. The expected outcome for each latency is computed from the strobe pipeline depth (completion iff L <= TIMEOUT_CYC-7). Each run must give exactly one of the two pulses: on the completion side, the right data; on the timeout side, a request held for exactly TIMEOUT_CYC cycles.

// File: rtl/hs_bus_pkg.sv
package hs_bus_pkg;
  typedef enum logic [1:0] {M_IDLE, M_SETUP, M_WAIT_ACK, M_WAIT_LOW} mst_state_e;
  typedef enum logic [1:0] {S_IDLE, S_ACCESS, S_ACK} slv_state_e;
endpackage

// File: rtl/hs_sync.sv
module hs_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= {sh_q[STAGES-2:0], d};
  end

  assign q = sh_q[STAGES-1];
endmodule

// File: rtl/hs_master.sv
module hs_master
  import hs_bus_pkg::*;
#(
  parameter int AW          = 8,
  parameter int DW          = 8,
  parameter int DECODE_CYC  = 3,
  parameter int TIMEOUT_CYC = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_valid,
  input  logic          cmd_write,
  input  logic [AW-1:0] cmd_addr,
  input  logic [DW-1:0] cmd_wdata,
  output logic          cmd_busy,
  output logic          cmd_done,
  output logic          cmd_timeout,
  output logic [DW-1:0] cmd_rdata,
  input  logic          ack_s,
  input  logic [DW-1:0] bus_data_in,
  output logic          bus_own,
  output logic          bus_req,
  output logic          bus_write,
  output logic [AW-1:0] bus_addr,
  output logic [DW-1:0] mst_wdata
);
  localparam int CMAX = (DECODE_CYC > TIMEOUT_CYC) ? DECODE_CYC : TIMEOUT_CYC;
  localparam int CW   = $clog2(CMAX + 1);
  localparam logic [CW-1:0] DEC_LAST = CW'(DECODE_CYC - 1);
  localparam logic [CW-1:0] TO_LAST  = CW'(TIMEOUT_CYC - 1);

  mst_state_e    state_q, state_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          done_q, done_d, to_q, to_d;
  logic          load_en, cap_en;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] wdata_q, rdata_q;
  logic          wr_q;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    done_d  = 1'b0;
    to_d    = 1'b0;
    load_en = 1'b0;
    cap_en  = 1'b0;
    unique case (state_q)
      M_IDLE: begin
        if (cmd_valid && !ack_s) begin
          state_d = M_SETUP;
          cnt_d   = '0;
          load_en = 1'b1;
        end
      end
      M_SETUP: begin
        if (cnt_q == DEC_LAST) begin
          state_d = M_WAIT_ACK;
          cnt_d   = '0;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      M_WAIT_ACK: begin
        if (ack_s) begin
          state_d = M_WAIT_LOW;
          cap_en  = 1'b1;
        end else if (cnt_q == TO_LAST) begin
          state_d = M_IDLE;
          to_d    = 1'b1;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      M_WAIT_LOW: begin
        if (!ack_s) begin
          state_d = M_IDLE;
          done_d  = 1'b1;
        end
      end
      default: state_d = M_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= M_IDLE;
      cnt_q   <= '0;
      done_q  <= 1'b0;
      to_q    <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
      wr_q    <= 1'b0;
      rdata_q <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      done_q  <= done_d;
      to_q    <= to_d;
      if (load_en) begin
        addr_q  <= cmd_addr;
        wdata_q <= cmd_wdata;
        wr_q    <= cmd_write;
      end
      if (cap_en) rdata_q <= bus_data_in;
    end
  end

  assign bus_own     = (state_q != M_IDLE);
  assign bus_req     = (state_q == M_WAIT_ACK);
  assign cmd_busy    = bus_own;
  assign cmd_done    = done_q;
  assign cmd_timeout = to_q;
  assign cmd_rdata   = rdata_q;
  assign bus_write   = wr_q;
  assign bus_addr    = addr_q;
  assign mst_wdata   = wdata_q;
endmodule

// File: rtl/hs_slave.sv
module hs_slave
  import hs_bus_pkg::*;
#(
  parameter int AW = 8,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_s,
  input  logic          bus_write,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_data_in,
  output logic          bus_ack,
  output logic          slv_drive,
  output logic [DW-1:0] slv_data,
  output logic          dev_sel,
  output logic          dev_write,
  output logic [AW-1:0] dev_addr,
  output logic [DW-1:0] dev_wdata,
  input  logic          dev_ready,
  input  logic [DW-1:0] dev_rdata
);
  slv_state_e    state_q, state_d;
  logic          lat_en, cap_en;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] wdata_q, rdata_q;
  logic          wr_q;

  always_comb begin
    state_d = state_q;
    lat_en  = 1'b0;
    cap_en  = 1'b0;
    unique case (state_q)
      S_IDLE: begin
        if (req_s) begin
          state_d = S_ACCESS;
          lat_en  = 1'b1;
        end
      end
      S_ACCESS: begin
        if (!req_s) begin
          state_d = S_IDLE;
        end else if (dev_ready) begin
          state_d = S_ACK;
          cap_en  = 1'b1;
        end
      end
      S_ACK: begin
        if (!req_s) state_d = S_IDLE;
      end
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      addr_q  <= '0;
      wdata_q <= '0;
      wr_q    <= 1'b0;
      rdata_q <= '0;
    end else begin
      state_q <= state_d;
      if (lat_en) begin
        addr_q  <= bus_addr;
        wdata_q <= bus_data_in;
        wr_q    <= bus_write;
      end
      if (cap_en) rdata_q <= dev_rdata;
    end
  end

  assign bus_ack   = (state_q == S_ACK);
  assign slv_drive = (state_q == S_ACK) && !wr_q;
  assign slv_data  = rdata_q;
  assign dev_sel   = (state_q == S_ACCESS);
  assign dev_write = wr_q;
  assign dev_addr  = addr_q;
  assign dev_wdata = wdata_q;
endmodule

// File: rtl/hs_bus_top.sv
module hs_bus_top #(
  parameter int AW          = 8,
  parameter int DW          = 8,
  parameter int DECODE_CYC  = 3,
  parameter int TIMEOUT_CYC = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_valid,
  input  logic          cmd_write,
  input  logic [AW-1:0] cmd_addr,
  input  logic [DW-1:0] cmd_wdata,
  output logic          cmd_busy,
  output logic          cmd_done,
  output logic          cmd_timeout,
  output logic [DW-1:0] cmd_rdata,
  output logic          bus_own,
  output logic          bus_req,
  output logic          bus_ack,
  output logic          bus_write,
  output logic [AW-1:0] bus_addr,
  output logic [DW-1:0] bus_data,
  output logic          slv_drive,
  output logic          dev_sel,
  output logic          dev_write,
  output logic [AW-1:0] dev_addr,
  output logic [DW-1:0] dev_wdata,
  input  logic          dev_ready,
  input  logic [DW-1:0] dev_rdata
);
  logic          req_s, ack_s;
  logic [DW-1:0] mst_wdata, slv_data;

  hs_sync #(.STAGES(SYNC_STAGES)) req_sync_i (
    .clk(clk), .rst_n(rst_n), .d(bus_req), .q(req_s));
  hs_sync #(.STAGES(SYNC_STAGES)) ack_sync_i (
    .clk(clk), .rst_n(rst_n), .d(bus_ack), .q(ack_s));

  hs_master #(.AW(AW), .DW(DW), .DECODE_CYC(DECODE_CYC), .TIMEOUT_CYC(TIMEOUT_CYC)) mst_i (
    .clk(clk), .rst_n(rst_n),
    .cmd_valid(cmd_valid), .cmd_write(cmd_write), .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata),
    .cmd_busy(cmd_busy), .cmd_done(cmd_done), .cmd_timeout(cmd_timeout), .cmd_rdata(cmd_rdata),
    .ack_s(ack_s), .bus_data_in(bus_data),
    .bus_own(bus_own), .bus_req(bus_req), .bus_write(bus_write), .bus_addr(bus_addr),
    .mst_wdata(mst_wdata));

  hs_slave #(.AW(AW), .DW(DW)) slv_i (
    .clk(clk), .rst_n(rst_n),
    .req_s(req_s), .bus_write(bus_write), .bus_addr(bus_addr), .bus_data_in(bus_data),
    .bus_ack(bus_ack), .slv_drive(slv_drive), .slv_data(slv_data),
    .dev_sel(dev_sel), .dev_write(dev_write), .dev_addr(dev_addr), .dev_wdata(dev_wdata),
    .dev_ready(dev_ready), .dev_rdata(dev_rdata));

  // Resolved shared data path: slave read drive, else master write drive.
  always_comb begin
    if (slv_drive)                 bus_data = slv_data;
    else if (bus_own && bus_write) bus_data = mst_wdata;
    else                           bus_data = '0;
  end
endmodule

// File: rtl/hs_bus_chk.sv
module hs_bus_chk #(
  parameter int AW         = 8,
  parameter int DECODE_CYC = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          bus_own,
  input logic          bus_req,
  input logic          bus_ack,
  input logic          bus_write,
  input logic [AW-1:0] bus_addr,
  input logic          slv_drive,
  input logic          cmd_done,
  input logic          cmd_timeout
);
  int own_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             own_cnt <= 0;
    else if (!bus_own)      own_cnt <= 0;
    else if (own_cnt < 1000) own_cnt <= own_cnt + 1;
  end

  // R2
  req_own_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req |-> bus_own);

  // R3
  decode_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_req) |-> (own_cnt == DECODE_CYC));

  // R6
  req_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(bus_req) && !cmd_timeout) |-> $past(bus_ack, 3));

  // R7
  ack_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bus_ack) |-> !$past(bus_req, 3));

  // R8
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_done |-> (!bus_ack && !bus_req));

  // R9
  slv_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    slv_drive |-> (bus_ack && !bus_write));

  // R10
  done_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(cmd_done && cmd_timeout));

  // R12
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_own && $past(bus_own)) |-> ($stable(bus_addr) && $stable(bus_write)));
endmodule

bind hs_bus_top hs_bus_chk #(.AW(AW), .DECODE_CYC(DECODE_CYC)) chk_i (
  .clk(clk), .rst_n(rst_n), .bus_own(bus_own), .bus_req(bus_req), .bus_ack(bus_ack),
  .bus_write(bus_write), .bus_addr(bus_addr), .slv_drive(slv_drive),
  .cmd_done(cmd_done), .cmd_timeout(cmd_timeout));

// File: tb/hs_bus_tb.sv
`timescale 1ns/1ps
module hs_bus_top_tb_top;
  localparam int AW = 8;
  localparam int DW = 8;
  localparam int DEC = 3;
  localparam int TO  = 16;

  logic clk = 1'b0;
  logic rst_n;
  logic cmd_valid, cmd_write;
  logic [AW-1:0] cmd_addr;
  logic [DW-1:0] cmd_wdata;
  logic cmd_busy, cmd_done, cmd_timeout;
  logic [DW-1:0] cmd_rdata;
  logic bus_own, bus_req, bus_ack, bus_write, slv_drive;
  logic [AW-1:0] bus_addr;
  logic [DW-1:0] bus_data;
  logic dev_sel, dev_write, dev_ready;
  logic [AW-1:0] dev_addr;
  logic [DW-1:0] dev_wdata, dev_rdata;

  int total = 0;
  int bad   = 0;

  always #4 clk = ~clk;

  hs_bus_top #(.AW(AW), .DW(DW), .DECODE_CYC(DEC), .TIMEOUT_CYC(TO)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .cmd_valid(cmd_valid), .cmd_write(cmd_write), .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata),
    .cmd_busy(cmd_busy), .cmd_done(cmd_done), .cmd_timeout(cmd_timeout), .cmd_rdata(cmd_rdata),
    .bus_own(bus_own), .bus_req(bus_req), .bus_ack(bus_ack), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_data(bus_data), .slv_drive(slv_drive),
    .dev_sel(dev_sel), .dev_write(dev_write), .dev_addr(dev_addr), .dev_wdata(dev_wdata),
    .dev_ready(dev_ready), .dev_rdata(dev_rdata));

  function automatic logic [DW-1:0] dev_fn(input logic [AW-1:0] a);
    return DW'(a * 3 + 1);
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic run_txn(input bit wr, input logic [AW-1:0] a, input logic [DW-1:0] d,
                         input int lat, input bit poke);
    int own_cyc = 0, req_cyc = 0, n = 0, quiet = 0, dones = 0, tos = 0;
    bit req_seen = 0, drv_bad = 0, done_bad = 0, ok_exp;
    logic [AW-1:0] sa = '0, req_addr = '0;
    logic [DW-1:0] sd = '0;
    logic sw = 1'b0;
    @(negedge clk);
    cmd_valid = 1'b1; cmd_write = wr; cmd_addr = a; cmd_wdata = d;
    @(negedge clk);
    cmd_valid = 1'b0;
    for (int cyc = 0; cyc < 300; cyc++) begin
      if (bus_req && !req_seen) req_addr = bus_addr;
      if (bus_own && !req_seen && !bus_req) own_cyc++;
      if (bus_req) begin req_seen = 1; req_cyc++; end
      if (dev_sel) begin
        sa = dev_addr; sd = dev_wdata; sw = dev_write;
        dev_ready = (n >= lat);
        n++;
      end else begin
        n = 0; dev_ready = 1'b0;
      end
      dev_rdata = dev_fn(dev_addr);
      if (slv_drive && (!bus_ack || bus_write || bus_data != dev_fn(sa))) drv_bad = 1;
      if (cmd_done) begin dones++; if (bus_ack || bus_req) done_bad = 1; end
      if (cmd_timeout) tos++;
      if (poke && cyc == 2) begin
        cmd_valid = 1'b1; cmd_write = ~wr; cmd_addr = ~a; cmd_wdata = ~d;
      end
      if (poke && cyc == 3) cmd_valid = 1'b0;
      if ((dones + tos) > 0 && !bus_ack && !dev_sel && !cmd_busy && !bus_req) quiet++;
      else quiet = 0;
      if (quiet >= 5) break;
      @(negedge clk);
    end
    ok_exp = (lat <= TO - 7);
    chk(own_cyc == DEC, "R3 decode gap", own_cyc, DEC);
    chk(req_addr == a, "R2 address at request", int'(req_addr), int'(a));
    chk(!drv_bad, "R9 slave drive", int'(drv_bad), 0);
    if (ok_exp) begin
      chk(dones == 1 && tos == 0, "R11 R6 completion", dones * 10 + tos, 10);
      chk(!done_bad, "R8 done with strobes low", int'(done_bad), 0);
      if (wr) begin
        chk(sw == 1'b1 && sa == a, "R4 write addr/dir", int'(sa), int'(a));
        chk(sd == d, "R4 write data", int'(sd), int'(d));
      end else begin
        chk(sw == 1'b0, "R5 read dir", int'(sw), 0);
        chk(cmd_rdata == dev_fn(a), "R5 read data", int'(cmd_rdata), int'(dev_fn(a)));
      end
    end else begin
      chk(tos == 1 && dones == 0, "R10 timeout pulse", tos * 10 + dones, 10);
      chk(req_cyc == TO, "R10 request width", req_cyc, TO);
    end
    if (poke) chk(sa == a && sw == wr, "R12 ignored command", int'(sa), int'(a));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    cmd_valid = 1'b0; cmd_write = 1'b0; cmd_addr = '0; cmd_wdata = '0;
    dev_ready = 1'b0; dev_rdata = '0;
    repeat (4) @(negedge clk);
    chk(!bus_req && !bus_ack && !bus_own && !slv_drive && !dev_sel, "R1 reset strobes",
        int'({bus_req, bus_ack, bus_own, slv_drive, dev_sel}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!cmd_busy && !cmd_done && !cmd_timeout && !bus_req, "R1 after release",
        int'({cmd_busy, cmd_done, cmd_timeout, bus_req}), 0);
    for (int rw = 0; rw < 2; rw++) begin
      for (int lat = 0; lat <= 12; lat++) begin
        run_txn(rw[0], AW'(lat * 19 + rw * 7 + 1), DW'(lat * 11 + 5), lat, 1'b0);
      end
    end
    run_txn(1'b1, 8'hA5, 8'h3C, 2, 1'b1);
    run_txn(1'b0, 8'h5A, 8'h00, 2, 1'b1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule